// File: doc/BRIEF.md
# Locked-Antiphase and Sign-Magnitude PWM Speed Generator

This block turns a signed 8-bit speed command into the two control levels of a full-bridge motor driver: a direction level (`dir_o`) and a bridge enable (`en_o`). It offers two drive schemes, chosen by `mode_i`.

In sign-magnitude drive (`mode_i` = 0), `dir_o` is a steady level taken from the sign of the command. `en_o` is pulse-width modulated by the magnitude of the command. In locked-antiphase drive (`mode_i` = 1), `en_o` stays high and `dir_o` alone carries the PWM. There, a 50 % duty means standstill, and the two duty extremes mean full speed in opposite directions.

A stop input pulls the enable low in either scheme. The PWM period comes from an unsigned compare value. Changes to the command, the scheme or the period are taken only at a period boundary.

Top module: `speed_pwm_gen`

## Requirements
- R1: In locked-antiphase mode, `dir_o` is high for floor(D*P/256) cycles of each P-cycle period. D = 128 + cmd, read as two's complement, so cmd 0 gives 50 %.
- R2: In locked-antiphase mode, `en_o` is high in every cycle after the one in which `stop_i` was sampled low.
- R3: In sign-magnitude mode, `dir_o` is 1 for cmd >= 0 and 0 for negative cmd. `en_o` is high for floor(2*|cmd|*P/256) cycles per period, so cmd 0 keeps `en_o` low.
- R4: Saturation. In locked-antiphase mode, cmd +127 holds `dir_o` high with no low pulse, and cmd -128 holds it low. In sign-magnitude mode, cmd +127, -127 and -128 hold `en_o` high with no low pulse.
- R5: While `stop_i` is sampled high, `en_o` is low in the following cycle, in both modes. The PWM on `dir_o` keeps running.
- R6: The PWM period is `period_i` + 1 clock cycles.
- R7: A `period_i` value below CLK_HZ/MAX_PWM_HZ - 1 is raised to that value. With the defaults, this caps the PWM rate at 100 kHz (period of 100 cycles).
- R8: Command, mode and period are sampled only on the last cycle of a period. A change in the middle of a period leaves that period's pulse unchanged, so no runt pulse appears.
- R9: During reset, `dir_o` and `en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 8 | Signed speed command, two's complement |
| mode_i | input | 1 | 0 = sign-magnitude, 1 = locked-antiphase |
| stop_i | input | 1 | Forces the bridge enable low |
| period_i | input | PW | Period compare value; period is this value + 1 cycles |
| dir_o | output | 1 | Direction level to the bridge (PWM in locked-antiphase mode) |
| en_o | output | 1 | Bridge enable (PWM in sign-magnitude mode) |

## Verification
The hardest case to reach from the ports is a command change that lands in the middle of a period. The period counter is not visible from outside, so the stimulus waits for the rising edge of `dir_o` in locked-antiphase mode, which marks the start of a period. It then jumps the command to full scale ten cycles into that period. The bench counts high cycles over exactly one period from that edge, which must still show the old 50 % duty. The next full window must then be solidly high.

// File: rtl/speed_pwm_gen.sv
module speed_pwm_gen #(
  parameter int PW         = 16,
  parameter int CLK_HZ     = 10_000_000,
  parameter int MAX_PWM_HZ = 100_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic signed [7:0] cmd_i,
  input  logic              mode_i,
  input  logic              stop_i,
  input  logic [PW-1:0]     period_i,
  output logic              dir_o,
  output logic              en_o
);
  localparam int            MIN_TICKS = (CLK_HZ + MAX_PWM_HZ - 1) / MAX_PWM_HZ;
  localparam logic [PW-1:0] MIN_TOP   = PW'(MIN_TICKS - 1);
  localparam int            HW        = PW + 1;
  localparam int            MW        = PW + 10;

  logic [PW-1:0] cnt, per_q;
  logic [HW-1:0] hi_q;
  logic          mode_q, fwd_q;

  logic          wrap;
  logic [PW-1:0] top_nx;
  logic [7:0]    mag;
  logic [8:0]    sm_code, lap_code, code;
  logic [MW-1:0] prod;
  logic [HW-1:0] hi_nx;
  logic          pwm;

  assign wrap     = (cnt == per_q);
  assign top_nx   = (period_i < MIN_TOP) ? MIN_TOP : period_i;
  assign mag      = cmd_i[7] ? 8'(-cmd_i) : 8'(cmd_i);
  assign sm_code  = (mag >= 8'd127) ? 9'd256 : {mag, 1'b0};
  assign lap_code = (cmd_i == 8'sd127) ? 9'd256 : 9'd128 + {cmd_i[7], cmd_i};
  assign code     = mode_i ? lap_code : sm_code;
  assign prod     = MW'(code) * (MW'(top_nx) + MW'(1));
  assign hi_nx    = HW'(prod >> 8);
  assign pwm      = ({1'b0, cnt} < hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= MIN_TOP;
      per_q  <= MIN_TOP;
      hi_q   <= '0;
      mode_q <= 1'b0;
      fwd_q  <= 1'b0;
      dir_o  <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        per_q  <= top_nx;
        hi_q   <= hi_nx;
        mode_q <= mode_i;
        fwd_q  <= ~cmd_i[7];
      end
      dir_o <= mode_q ? pwm : fwd_q;
      en_o  <= !stop_i && (mode_q || pwm);
    end
  end
endmodule

// File: rtl/speed_pwm_gen_chk.sv
module speed_pwm_gen_chk #(
  parameter int PW         = 16,
  parameter int CLK_HZ     = 10_000_000,
  parameter int MAX_PWM_HZ = 100_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_i,
  input logic          en_o,
  input logic          mode_q,
  input logic [PW-1:0] cnt,
  input logic [PW-1:0] per_q,
  input logic [PW:0]   hi_q
);
  localparam int            MIN_TICKS = (CLK_HZ + MAX_PWM_HZ - 1) / MAX_PWM_HZ;
  localparam logic [PW-1:0] MIN_TOP   = PW'(MIN_TICKS - 1);

  a_r5_stop_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !en_o);

  a_r2_lap_enable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && mode_q) |=> en_o);

  a_r3_zero_duty_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && hi_q == '0) |=> !en_o);

  a_r7_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= MIN_TOP);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_q);

  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != per_q) |=> ($stable(hi_q) && $stable(mode_q) && $stable(per_q)));
endmodule

bind speed_pwm_gen speed_pwm_gen_chk #(.PW(PW), .CLK_HZ(CLK_HZ), .MAX_PWM_HZ(MAX_PWM_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .en_o(en_o),
  .mode_q(mode_q), .cnt(cnt), .per_q(per_q), .hi_q(hi_q)
);

// File: tb/speed_pwm_gen_test.sv
module speed_pwm_gen_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PW = 16;
  localparam int  N  = 14;

  // mode, cmd, period_i, window, expected dir highs, expected en highs
  localparam int T_MODE[N] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int T_CMD [N] = '{0, 64, -64, 127, -128, 32, 64, 50, -50, 0, -128, 127, 100, -127};
  localparam int T_PER [N] = '{255, 255, 255, 255, 255, 199, 9, 255, 255, 255, 255, 255, 199, 255};
  localparam int T_WIN [N] = '{256, 256, 256, 256, 256, 200, 100, 256, 256, 256, 256, 256, 200, 256};
  localparam int T_DIR [N] = '{128, 192, 64, 256, 0, 125, 75, 256, 0, 256, 0, 256, 200, 0};
  localparam int T_EN  [N] = '{256, 256, 256, 256, 256, 200, 100, 100, 100, 0, 256, 256, 156, 256};
  localparam string T_REQ[N] = '{"R1", "R1", "R1", "R4", "R4", "R6", "R7", "R3", "R3", "R3", "R4", "R4", "R3", "R4"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic signed [7:0] cmd = '0;
  logic mode = 1'b0, stop = 1'b0;
  logic [PW-1:0] period = 16'd255;
  logic dir, en;
  int checks = 0, errors = 0, nd, ne;
  bit done = 1'b0;

  speed_pwm_gen #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .mode_i(mode), .stop_i(stop),
    .period_i(period), .dir_o(dir), .en_o(en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic measure(input int win);
    nd = 0; ne = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      nd += int'(dir);
      ne += int'(en);
    end
  endtask

  task automatic wait_dir_rise();
    logic prev;
    prev = dir;
    forever begin
      @(negedge clk);
      if (dir && !prev) break;
      prev = dir;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cycles(4);
    check("R9", "dir during reset", int'(dir), 0);
    check("R9", "en during reset", int'(en), 0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      mode = T_MODE[i][0];
      cmd = 8'(T_CMD[i]);
      period = PW'(T_PER[i]);
      wait_cycles(600);
      measure(T_WIN[i]);
      check(T_REQ[i], $sformatf("row %0d dir highs", i), nd, T_DIR[i]);
      check(T_REQ[i], $sformatf("row %0d en highs", i), ne, T_EN[i]);
    end

    // R6: rising edges of dir are period_i+1 cycles apart
    mode = 1'b1; cmd = 8'sd0; period = 16'd149;
    wait_cycles(600);
    wait_dir_rise();
    nd = 0;
    begin
      logic prev;
      prev = dir;
      forever begin
        @(negedge clk);
        nd++;
        if (dir && !prev) break;
        prev = dir;
      end
    end
    check("R6", "edge spacing", nd, 150);

    // R5: stop in locked-antiphase mode, PWM keeps running
    period = 16'd255; cmd = 8'sd64; stop = 1'b1;
    wait_cycles(600);
    measure(256);
    check("R5", "lap stop en highs", ne, 0);
    check("R5", "lap stop dir highs", nd, 192);

    // R5: stop in sign-magnitude mode at full scale
    mode = 1'b0; cmd = 8'sd127;
    wait_cycles(600);
    measure(256);
    check("R5", "sm stop en highs", ne, 0);
    stop = 1'b0;
    wait_cycles(2);
    measure(256);
    check("R5", "sm release en highs", ne, 256);

    // R5: stop takes effect in the next cycle
    stop = 1'b1;
    @(negedge clk);
    check("R5", "en one cycle after stop", int'(en), 0);
    stop = 1'b0;

    // R8: change mid-period has no effect until the boundary
    mode = 1'b1; cmd = 8'sd0;
    wait_cycles(600);
    wait_dir_rise();
    nd = 1;
    for (int k = 1; k < 256; k++) begin
      if (k == 10) cmd = 8'sd127;
      @(negedge clk);
      nd += int'(dir);
    end
    check("R8", "period with mid change", nd, 128);
    measure(256);
    check("R8", "following period", nd, 256);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule